// File: doc/BRIEF.md
# Down-Counting Pulse-Width Modulator with Period Sync

This block produces a pulse-width modulated level whose period is a fixed power of two of clock cycles (256 at the default 8-bit width). An internal counter steps downward from its maximum to zero and then wraps. The duty value on the data input sets how many clocks per period the output is high, and the high part always sits at the tail of each period.

A one-clock sync strobe marks the last cycle of every period, while the counter holds zero. The duty input is captured only on the clock edge that ends that strobe cycle. The new value therefore governs exactly the next whole period, and a duty change made at any other time cannot cut or stretch a pulse.

Top module: `dpwm_sync`

## Requirements
- R1: `sync_out` is high for exactly one clock every 2**CNT_W clocks, in the cycle where the internal count is zero. After reset is released, the first strobe falls in cycle position 2**CNT_W-1 of the first period, counting the release cycle as position 0.
- R2: While reset is asserted and in the first cycle after release, `pwm_out` and `sync_out` are low. The count restarts at its maximum and the captured duty is cleared to zero, so the whole first period is low.
- R3: In each period, `pwm_out` is high for exactly D clocks, where D is the captured duty. With cycle position p counted from 0 at the cycle after a strobe, the output is high exactly when (2**CNT_W-1-p) < D.
- R4: A captured duty of 0 keeps `pwm_out` low for the entire period.
- R5: A captured duty of 2**CNT_W-1 gives a high time of all but one clock. The single low cycle is the first cycle of the period.
- R6: `duty_in` is captured only on the rising edge that ends a `sync_out` cycle. Values present at any other edge have no effect on `pwm_out`.
- R7: `pwm_out` rises on the edge after the cycle where the count equals the captured duty. It falls on the edge after the cycle where the count is zero. When both happen in the same cycle, the fall wins.
- R8: A duty captured at the end of a strobe cycle takes effect in the period that starts immediately after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| duty_in | input | CNT_W | Requested high time in clocks per period |
| pwm_out | output | 1 | Modulated output level |
| sync_out | output | 1 | One-clock strobe in the last cycle of each period |

## Verification
The bench builds the block at the default CNT_W of 8, so one period is 256 clocks. At that width the duty extremes 0, 1, 2**CNT_W-2 and 2**CNT_W-1 are each reached within a few periods. During every period the bench deliberately drives unrelated values onto the duty input. This shows that only the value present at the strobe's closing edge shapes the next period.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    // Action taken on the output level at the next edge
    typedef enum logic [1:0] {
        LVL_HOLD = 2'd0,
        LVL_SET  = 2'd1,
        LVL_CLR  = 2'd2
    } lvl_act_e;

    localparam int unsigned DPWM_DEF_W = 8;

endpackage

// File: rtl/dpwm_down_counter.sv
module dpwm_down_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == CNT_ZERO) begin
            st_d.cnt = CNT_MAX;
        end else begin
            st_d.cnt = st_q.cnt - CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= CNT_MAX;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign wrap_o = (st_q.cnt == CNT_ZERO);

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != CNT_ZERO) |=> (st_q.cnt == $past(st_q.cnt) - CNT_ONE));

    // R1
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_ZERO) |=> (st_q.cnt == CNT_MAX));

endmodule

// File: rtl/dpwm_duty_latch.sv
module dpwm_duty_latch #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] duty_i,
    output logic [CNT_W-1:0] duty_o
);
    typedef struct packed {
        logic [CNT_W-1:0] duty;
    } duty_st_t;

    duty_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.duty = duty_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.duty <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign duty_o = st_q.duty;

    // R6
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(st_q.duty));

    // R8
    duty_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.duty == $past(duty_i)));

endmodule

// File: rtl/dpwm_level_stage.sv
module dpwm_level_stage
    import dpwm_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic             wrap_i,
    output logic             pwm_o
);
    typedef struct packed {
        logic lvl;
    } lvl_st_t;

    lvl_st_t  st_d, st_q;
    lvl_act_e act;

    always_comb begin
        // Clearing at wrap has priority, which keeps a zero duty low
        if (wrap_i) begin
            act = LVL_CLR;
        end else if (cnt_i == duty_i) begin
            act = LVL_SET;
        end else begin
            act = LVL_HOLD;
        end

        st_d = st_q;
        unique case (act)
            LVL_SET:  st_d.lvl = 1'b1;
            LVL_CLR:  st_d.lvl = 1'b0;
            default:  st_d.lvl = st_q.lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lvl <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o = st_q.lvl;

    // R7
    pwm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.lvl) |-> ($past(cnt_i) == $past(duty_i)) && !$past(wrap_i));

    // R7
    pwm_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> !st_q.lvl);

    // R4
    pwm_zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_i == '0) |-> !st_q.lvl);

endmodule

// File: rtl/dpwm_sync.sv
module dpwm_sync #(
    parameter int unsigned CNT_W = dpwm_pkg::DPWM_DEF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] duty_in,
    output logic             pwm_out,
    output logic             sync_out
);
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] duty_w;
    logic             wrap_w;

    dpwm_down_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_o  (cnt_w),
        .wrap_o (wrap_w)
    );

    // The duty is taken on the edge that ends the strobe cycle
    dpwm_duty_latch #(.CNT_W(CNT_W)) i_duty (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (wrap_w),
        .duty_i (duty_in),
        .duty_o (duty_w)
    );

    dpwm_level_stage #(.CNT_W(CNT_W)) i_lvl (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_i  (cnt_w),
        .duty_i (duty_w),
        .wrap_i (wrap_w),
        .pwm_o  (pwm_out)
    );

    assign sync_out = wrap_w;

    // R1
    sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |=> !sync_out);

    // R5
    pwm_low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |=> !pwm_out);

endmodule

// File: tb/test_dpwm_sync.sv
module test_dpwm_sync;
    localparam int W   = 8;
    localparam int PER = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] duty_in = '0;
    logic         pwm_out;
    logic         sync_out;

    int errors = 0;
    int checks = 0;
    int periods_done = 0;
    int exp_q[$];

    dpwm_sync #(.CNT_W(W)) i_dpwm_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .duty_in  (duty_in),
        .pwm_out  (pwm_out),
        .sync_out (sync_out)
    );

    always #2 clk = ~clk;

    // Driver: at each strobe, present the next duty and queue it for the
    // following period, then scramble the input for the rest of the period
    task automatic drive_duty(input int v, input int junk);
        do @(negedge clk); while (!sync_out);
        duty_in = v[W-1:0];
        exp_q.push_back(v);
        @(negedge clk);
        duty_in = junk[W-1:0];
    endtask

    // Monitor: compares each finished period against the queued duty
    initial begin
        int pos, hi, pat_bad, syn_bad, exp_v;
        bit exp_lvl;
        @(posedge rst_n);
        checks++;
        if (pwm_out !== 1'b0 || sync_out !== 1'b0) begin
            errors++;
            $display("FAIL R2 reset state: pwm=%b sync=%b expected 0 0", pwm_out, sync_out);
        end
        pos = 0; hi = 0; pat_bad = 0; syn_bad = 0;
        exp_v = (exp_q.size() > 0) ? exp_q[0] : 0;
        forever begin
            exp_lvl = ((PER - 1 - pos) < exp_v);
            if (pwm_out !== exp_lvl) pat_bad++;
            if (pwm_out === 1'b1) hi++;
            if (pos != PER - 1 && sync_out !== 1'b0) syn_bad++;
            if (pos == PER - 1) begin
                checks++;
                if (syn_bad != 0 || sync_out !== 1'b1) begin
                    errors++;
                    $display("FAIL R1 strobe: stray=%0d final=%b expected 0 1", syn_bad, sync_out);
                end
                checks++;
                if (pat_bad != 0) begin
                    errors++;
                    $display("FAIL R3/R6/R7/R8 pulse shape duty=%0d: mismatched cycles=%0d expected 0",
                             exp_v, pat_bad);
                end
                checks++;
                if (hi != exp_v) begin
                    errors++;
                    if (exp_v == 0)
                        $display("FAIL R4 high time: %0d expected %0d", hi, exp_v);
                    else if (exp_v == PER - 1)
                        $display("FAIL R5 high time: %0d expected %0d", hi, exp_v);
                    else
                        $display("FAIL R3 high time: %0d expected %0d", hi, exp_v);
                end
                if (exp_q.size() > 0) void'(exp_q.pop_front());
                periods_done++;
                pos = 0; hi = 0; pat_bad = 0; syn_bad = 0;
                exp_v = (exp_q.size() > 0) ? exp_q[0] : 0;
            end else begin
                pos++;
            end
            @(negedge clk);
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired: periods=%0d expected 11", periods_done);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int vals [10] = '{5, 0, 255, 1, 128, 3, 200, 254, 0, 77};
        int junk [10] = '{250, 99, 0, 255, 7, 180, 1, 0, 255, 33};
        exp_q.push_back(0); // R2: first period uses the cleared duty
        duty_in = 8'd200;   // ignored: not sampled at a strobe (R6)
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            drive_duty(vals[i], junk[i]);
        end
        while (periods_done < 11) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule